// File: doc/BRIEF.md
# Multi-cycle 16-bit register-machine core

A small processor core that runs programs out of an external synchronous single-port memory. It has eight 16-bit registers. The highest one, r7, is the program counter. The counter clears to 0 on reset, steps by one on every word fetched, and is loaded in parallel when an instruction names it as destination, which makes a branch. All transfers inside the core go over one 16-bit internal bus. A control state machine drives that bus through a fixed sequence of time steps for each instruction.

The core reaches the memory through an address register (`addr_o`), a data-out register (`dout_o`) and a one-cycle write strobe (`wr_o`). Read data, which can be an instruction or a data word, returns on `din_i` one cycle after the memory samples the address. The state machine therefore puts a wait step between loading the address and sampling the data. Conditional moves test a zero flag and a carry flag. Together with writes to r7, these give loops and branches.

Top module: `mc16_core`

## Requirements
- R1: While `rst_ni` is low the core holds `addr_o`=0, `wr_o`=0 and `done_o`=0, and all registers are cleared. The first instruction after reset is fetched from word 0.
- R2: With `run_i` low the core stays idle between instructions. No `done_o` pulse occurs and `addr_o` does not change.
- R3: An instruction word carries its fields in `din_i[8:0]`: bits [8:6] are the opcode, [5:3] are rX and [2:0] are rY. The opcodes are mv=000, mvi=001, add=010, sub=011, ld=100, st=101, mvnz=110, mvnc=111. Each fetch increments r7.
- R4: mvi rX loads the word that follows the instruction into rX. Execution then resumes at the word after that immediate.
- R5: mv rX,rY copies rY into rX. With rY=r7 it yields the address of the next instruction. With rX=r7, both mv and mvi cause a jump.
- R6: add rX,rY and sub rX,rY write rX+rY and rX−rY modulo 2^16 into rX.
- R7: add and sub set z when the 16-bit result is zero. add sets c on carry-out, and sub sets c on a borrow (rX < rY). mv sets z from the moved value. mvi, ld, st, mvnz and mvnc leave both flags unchanged.
- R8: mvnz copies rY into rX only when z=0. mvnc copies only when c=0. Otherwise rX keeps its value.
- R9: ld rX,[rY] places rY on `addr_o` and loads the returned memory word into rX.
- R10: st rX,[rY] places rY on `addr_o` and rX on `dout_o`, and raises `wr_o` for exactly one cycle. That cycle is the instruction's completion cycle, and `addr_o` is stable during it.
- R11: `done_o` pulses for exactly one cycle when an instruction completes. With `run_i` held high, consecutive completions are 5 cycles apart for mv, mvnz and mvnc, and 7 cycles apart for mvi, add, sub, ld and st.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Lets the core leave idle and start the next instruction |
| din_i | input | 16 | Read data from memory (instruction or data) |
| addr_o | output | 16 | Memory address register |
| dout_o | output | 16 | Memory write data register |
| wr_o | output | 1 | Write strobe, high for one cycle per store |
| done_o | output | 1 | One-cycle pulse at instruction completion |

## Verification
Add and sub are swept over every ordered pair from a set of edge operands: 0, 1, 2, 0x1234, 0x7fff, 0x8000, 0xfffe and 0xffff. Each run stores the result and, through mvnz and mvnc, the state of z and c. This separates wrap-around, the borrow-versus-carry polarity, and zero detection on the result against zero detection on an operand. A second program mixes ld, a read of r7, mv-driven z changes, taken and untaken conditional moves, and a jump past a poisoned word. Any slip in program-counter timing or flag retention shows up as a wrong stored value. A third program measures the spacing between completion pulses for each instruction class and counts the write-strobe width, which exposes a missing or extra wait step.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

  typedef enum logic [2:0] {
    OP_MV   = 3'b000,
    OP_MVI  = 3'b001,
    OP_ADD  = 3'b010,
    OP_SUB  = 3'b011,
    OP_LD   = 3'b100,
    OP_ST   = 3'b101,
    OP_MVNZ = 3'b110,
    OP_MVNC = 3'b111
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F0,   // pc -> addr, pc++
    ST_F1,   // memory samples address
    ST_F2,   // capture instruction
    ST_EX,
    ST_MW,   // memory wait (mvi / ld)
    ST_MR,   // capture read data
    ST_AL,   // alu -> g
    ST_WB,   // g -> rX
    ST_SD,   // rX -> dout, arm write
    ST_SW    // write cycle
  } state_e;

  typedef enum logic [1:0] {
    BUS_REG,
    BUS_G,
    BUS_DIN
  } bus_e;

  typedef struct packed {
    logic ir_in;
    logic a_in;
    logic g_in;
    logic addr_in;
    logic dout_in;
    logic w_set;
    logic incr_pc;
    logic reg_we;
    logic sub;
    logic z_bus;
    logic done;
    bus_e bus;
  } ctrl_t;

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            dst_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     incr_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == NREG - 1) begin : g_pc
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 regs_o[i] <= '0;
        else if (we_i && dst_i == AW'(i))            regs_o[i] <= wdata_i;
        else if (incr_i)                             regs_o[i] <= regs_o[i] + 1'b1;
      end
    end else begin : g_gp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 regs_o[i] <= '0;
        else if (we_i && dst_i == AW'(i))            regs_o[i] <= wdata_i;
      end
    end
  end

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);

  logic [DW:0] ext;

  // bit DW is carry for add, borrow for sub
  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i};
    else       ext = {1'b0, a_i} + {1'b0, b_i};
  end

  assign res_o   = ext[DW-1:0];
  assign carry_o = ext[DW];

endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG),
  localparam int IW  = 3 + 2 * AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [IW-1:0] ir_i,
  input  logic          z_i,
  input  logic          c_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] bus_idx_o,
  output logic [AW-1:0] dst_idx_o
);

  localparam logic [AW-1:0] PC_IDX = AW'(NREG - 1);

  state_e state_q, state_d;
  op_e    op;
  logic [AW-1:0] rx, ry;

  assign op = op_e'(ir_i[IW-1 -: 3]);
  assign rx = ir_i[2*AW-1:AW];
  assign ry = ir_i[AW-1:0];
  assign dst_idx_o = rx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o    = '0;
    ctrl_o.bus = BUS_REG;
    bus_idx_o = PC_IDX;
    state_d   = state_q;
    unique case (state_q)
      ST_IDLE: if (run_i) state_d = ST_F0;
      ST_F0: begin
        ctrl_o.addr_in = 1'b1;
        ctrl_o.incr_pc = 1'b1;
        state_d        = ST_F1;
      end
      ST_F1: state_d = ST_F2;
      ST_F2: begin
        ctrl_o.ir_in = 1'b1;
        state_d      = ST_EX;
      end
      ST_EX: begin
        unique case (op)
          OP_MV: begin
            bus_idx_o     = ry;
            ctrl_o.reg_we = 1'b1;
            ctrl_o.z_bus  = 1'b1;
            ctrl_o.done   = 1'b1;
            state_d       = ST_IDLE;
          end
          OP_MVNZ, OP_MVNC: begin
            bus_idx_o     = ry;
            ctrl_o.reg_we = (op == OP_MVNZ) ? !z_i : !c_i;
            ctrl_o.done   = 1'b1;
            state_d       = ST_IDLE;
          end
          OP_MVI: begin
            ctrl_o.addr_in = 1'b1;
            ctrl_o.incr_pc = 1'b1;
            state_d        = ST_MW;
          end
          OP_LD: begin
            bus_idx_o      = ry;
            ctrl_o.addr_in = 1'b1;
            state_d        = ST_MW;
          end
          OP_ADD, OP_SUB: begin
            bus_idx_o   = rx;
            ctrl_o.a_in = 1'b1;
            state_d     = ST_AL;
          end
          OP_ST: begin
            bus_idx_o      = ry;
            ctrl_o.addr_in = 1'b1;
            state_d        = ST_SD;
          end
          default: state_d = ST_IDLE;
        endcase
      end
      ST_MW: state_d = ST_MR;
      ST_MR: begin
        ctrl_o.bus    = BUS_DIN;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.done   = 1'b1;
        state_d       = ST_IDLE;
      end
      ST_AL: begin
        bus_idx_o   = ry;
        ctrl_o.g_in = 1'b1;
        ctrl_o.sub  = (op == OP_SUB);
        state_d     = ST_WB;
      end
      ST_WB: begin
        ctrl_o.bus    = BUS_G;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.done   = 1'b1;
        state_d       = ST_IDLE;
      end
      ST_SD: begin
        bus_idx_o      = rx;
        ctrl_o.dout_in = 1'b1;
        ctrl_o.w_set   = 1'b1;
        state_d        = ST_SW;
      end
      ST_SW: begin
        ctrl_o.done = 1'b1;
        state_d     = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG),
  localparam int IW  = 3 + 2 * AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] dout_o,
  output logic          wr_o,
  output logic          done_o
);

  ctrl_t                   ctrl;
  logic [AW-1:0]           bus_idx, dst_idx;
  logic [NREG-1:0][DW-1:0] regs;
  logic [DW-1:0]           bus, a_q, g_q, alu_res;
  logic [IW-1:0]           ir_q;
  logic                    z_q, c_q, alu_c;

  mc16_ctrl #(.NREG(NREG)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .ir_i      (ir_q),
    .z_i       (z_q),
    .c_i       (c_q),
    .ctrl_o    (ctrl),
    .bus_idx_o (bus_idx),
    .dst_idx_o (dst_idx)
  );

  mc16_regfile #(.DW(DW), .NREG(NREG)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl.reg_we),
    .dst_i   (dst_idx),
    .wdata_i (bus),
    .incr_i  (ctrl.incr_pc),
    .regs_o  (regs)
  );

  mc16_alu #(.DW(DW)) i_alu (
    .a_i     (a_q),
    .b_i     (bus),
    .sub_i   (ctrl.sub),
    .res_o   (alu_res),
    .carry_o (alu_c)
  );

  always_comb begin
    unique case (ctrl.bus)
      BUS_G:   bus = g_q;
      BUS_DIN: bus = din_i;
      default: bus = regs[bus_idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q   <= '0;
      a_q    <= '0;
      g_q    <= '0;
      addr_o <= '0;
      dout_o <= '0;
      wr_o   <= 1'b0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
    end else begin
      wr_o <= ctrl.w_set;
      if (ctrl.ir_in)   ir_q   <= din_i[IW-1:0];
      if (ctrl.a_in)    a_q    <= bus;
      if (ctrl.addr_in) addr_o <= bus;
      if (ctrl.dout_in) dout_o <= bus;
      if (ctrl.g_in) begin
        g_q <= alu_res;
        z_q <= (alu_res == '0);
        c_q <= alu_c;
      end else if (ctrl.z_bus) begin
        z_q <= (bus == '0);
      end
    end
  end

  assign done_o = ctrl.done;

endmodule

// File: rtl/mc16_chk.sv
module mc16_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] addr_o,
  input logic          wr_o,
  input logic          done_o
);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_state_chk: assert (addr_o == '0 && !wr_o && !done_o);
    end
  end

  // R10
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  // R10
  wr_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $stable(addr_o));

  // R10
  wr_completes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> done_o);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

bind mc16_core mc16_chk #(.DW(DW)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_o (addr_o),
  .wr_o   (wr_o),
  .done_o (done_o)
);

// File: tb/test_mc16_core.sv
module test_mc16_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [15:0] q = '0;
  logic [15:0] addr, dout;
  logic        wr, done;
  logic [15:0] mem [256];
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc16_core i_mc16_core (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .run_i  (run),
    .din_i  (q),
    .addr_o (addr),
    .dout_o (dout),
    .wr_o   (wr),
    .done_o (done)
  );

  // synchronous single-port memory
  always @(posedge clk) begin
    if (wr) mem[addr[7:0]] <= dout;
    q <= mem[addr[7:0]];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [2:0] MV = 3'b000, MVI = 3'b001, ADD = 3'b010, SUB = 3'b011,
                         LD = 3'b100, ST = 3'b101, MVNZ = 3'b110, MVNC = 3'b111;

  function automatic logic [15:0] enc(logic [2:0] op, logic [2:0] x, logic [2:0] y);
    return {7'b0, op, x, y};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    run   = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic go();
    @(negedge clk);
    rst_n = 1'b1;
    run   = 1'b1;
  endtask

  // wait for the store to target, then let the write land
  task automatic wait_store(logic [15:0] target, string req);
    bit hit = 1'b0;
    for (int i = 0; i < 2000 && !hit; i++) begin
      @(negedge clk);
      if (wr && addr == target) hit = 1'b1;
    end
    chk(req, {15'b0, hit}, 16'h0001);
    repeat (2) @(negedge clk);
  endtask

  logic [15:0] vals [8];

  initial begin
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h1234,
             16'h7fff, 16'h8000, 16'hfffe, 16'hffff};

    // R1 reset state
    hold_reset();
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", addr, 16'h0000);
    chk("R1 wr in reset", {15'b0, wr}, 16'h0000);
    chk("R1 done in reset", {15'b0, done}, 16'h0000);

    // R2 run low: stays idle
    mem[0] = enc(MVI, 3'd1, 3'd0);
    mem[1] = 16'h0055;
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int dn = 0;
      int moved = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (done) dn++;
        if (addr != 16'h0000) moved++;
      end
      chk("R2 no done while run low", 16'(dn), 16'h0000);
      chk("R2 addr held while run low", 16'(moved), 16'h0000);
    end

    // R6 R7 R8 add/sub sweep
    for (int op = 0; op < 2; op++) begin
      for (int ia = 0; ia < 8; ia++) begin
        for (int ib = 0; ib < 8; ib++) begin
          logic [16:0] ext;
          logic [15:0] a, b, r;
          logic zf, cf;
          a = vals[ia];
          b = vals[ib];
          hold_reset();
          mem[0]  = enc(MVI, 3'd1, 3'd0);  mem[1]  = a;
          mem[2]  = enc(MVI, 3'd2, 3'd0);  mem[3]  = b;
          mem[4]  = enc(MVI, 3'd4, 3'd0);  mem[5]  = 16'h0001;
          mem[6]  = enc(MVI, 3'd5, 3'd0);  mem[7]  = 16'h0000;
          mem[8]  = enc(MVI, 3'd6, 3'd0);  mem[9]  = 16'h0000;
          mem[10] = enc(op == 0 ? ADD : SUB, 3'd1, 3'd2);
          mem[11] = enc(MVNZ, 3'd5, 3'd4);
          mem[12] = enc(MVNC, 3'd6, 3'd4);
          mem[13] = enc(MVI, 3'd3, 3'd0);  mem[14] = 16'h0080;
          mem[15] = enc(ST, 3'd1, 3'd3);
          mem[16] = enc(MVI, 3'd3, 3'd0);  mem[17] = 16'h0081;
          mem[18] = enc(ST, 3'd5, 3'd3);
          mem[19] = enc(MVI, 3'd3, 3'd0);  mem[20] = 16'h0082;
          mem[21] = enc(ST, 3'd6, 3'd3);
          mem[22] = enc(MVI, 3'd7, 3'd0);  mem[23] = 16'd22;
          go();
          wait_store(16'h0082, "R3 program reaches last store");
          ext = (op == 0) ? ({1'b0, a} + {1'b0, b}) : ({1'b0, a} - {1'b0, b});
          r  = ext[15:0];
          zf = (r == 16'h0000);
          cf = ext[16];
          chk(op == 0 ? "R6 add result" : "R6 sub result", mem[8'h80], r);
          chk("R7 R8 z flag via mvnz", mem[8'h81], zf ? 16'h0000 : 16'h0001);
          chk("R7 R8 c flag via mvnc", mem[8'h82], cf ? 16'h0000 : 16'h0001);
        end
      end
    end

    // R4 R5 R7 R8 R9 mixed program
    hold_reset();
    mem[0]  = enc(MVI, 3'd0, 3'd0);  mem[1] = 16'h00a0;
    mem[2]  = enc(LD, 3'd1, 3'd0);
    mem[3]  = enc(MV, 3'd2, 3'd7);
    mem[4]  = enc(MVI, 3'd3, 3'd0);  mem[5] = 16'h0000;
    mem[6]  = enc(MV, 3'd4, 3'd3);          // z=1
    mem[7]  = enc(MVI, 3'd5, 3'd0);  mem[8] = 16'h0001;
    mem[9]  = enc(MVI, 3'd6, 3'd0);  mem[10] = 16'h0000;
    mem[11] = enc(MVNZ, 3'd6, 3'd5);        // not taken
    mem[12] = enc(MV, 3'd4, 3'd5);          // z=0
    mem[13] = enc(LD, 3'd0, 3'd0);          // ld leaves z
    mem[14] = enc(MVI, 3'd3, 3'd0);  mem[15] = 16'h0000;
    mem[16] = enc(MVNZ, 3'd3, 3'd5);        // taken
    mem[17] = enc(MVI, 3'd0, 3'd0);  mem[18] = 16'd21;
    mem[19] = enc(MV, 3'd7, 3'd0);          // jump to 21
    mem[20] = enc(MV, 3'd1, 3'd3);          // poisoned
    mem[21] = enc(MVI, 3'd0, 3'd0);  mem[22] = 16'h0090;
    mem[23] = enc(ST, 3'd1, 3'd0);
    mem[24] = enc(MVI, 3'd0, 3'd0);  mem[25] = 16'h0091;
    mem[26] = enc(ST, 3'd2, 3'd0);
    mem[27] = enc(MVI, 3'd0, 3'd0);  mem[28] = 16'h0092;
    mem[29] = enc(ST, 3'd6, 3'd0);
    mem[30] = enc(MVI, 3'd0, 3'd0);  mem[31] = 16'h0093;
    mem[32] = enc(ST, 3'd3, 3'd0);
    mem[33] = enc(MVI, 3'd7, 3'd0);  mem[34] = 16'd33;
    mem[8'ha0] = 16'hbeef;
    go();
    wait_store(16'h0093, "R5 program reaches last store");
    chk("R9 R5 ld value kept across jump", mem[8'h90], 16'hbeef);
    chk("R5 mv from r7 gives next address", mem[8'h91], 16'h0004);
    chk("R8 mvnz not taken when z=1 from mv", mem[8'h92], 16'h0000);
    chk("R7 R8 mvnz taken after mv clears z", mem[8'h93], 16'h0001);
    chk("R4 immediate word untouched", mem[1], 16'h00a0);

    // R10 R11 timing and strobe width
    hold_reset();
    mem[0] = enc(MV, 3'd1, 3'd0);
    mem[1] = enc(MVI, 3'd2, 3'd0);  mem[2] = 16'h0050;
    mem[3] = enc(ADD, 3'd1, 3'd2);
    mem[4] = enc(LD, 3'd3, 3'd2);
    mem[5] = enc(ST, 3'd1, 3'd2);
    mem[6] = enc(MV, 3'd4, 3'd1);
    mem[7] = enc(MVI, 3'd7, 3'd0);  mem[8] = 16'd7;
    mem[8'h50] = 16'h1111;
    go();
    begin
      int t [6];
      int n = 0;
      int wcyc = 0;
      int wmax = 0;
      int run_len = 0;
      int dmax = 0;
      int dlen = 0;
      logic [15:0] wa = '0, wd = '0;
      for (int i = 0; i < 200 && n < 6; i++) begin
        @(negedge clk);
        if (wr) begin
          wcyc++; run_len++; wa = addr; wd = dout;
          if (run_len > wmax) wmax = run_len;
        end else run_len = 0;
        if (done) begin
          t[n] = i; n++; dlen++;
          if (dlen > dmax) dmax = dlen;
        end else dlen = 0;
      end
      chk("R11 six completions seen", 16'(n), 16'd6);
      if (n == 6) begin
        chk("R11 mvi spacing", 16'(t[1] - t[0]), 16'd7);
        chk("R11 add spacing", 16'(t[2] - t[1]), 16'd7);
        chk("R11 ld spacing", 16'(t[3] - t[2]), 16'd7);
        chk("R11 st spacing", 16'(t[4] - t[3]), 16'd7);
        chk("R11 mv spacing", 16'(t[5] - t[4]), 16'd5);
      end
      chk("R11 done width", 16'(dmax), 16'd1);
      chk("R10 one write cycle", 16'(wcyc), 16'd1);
      chk("R10 write width", 16'(wmax), 16'd1);
      chk("R10 store address", wa, 16'h0050);
      chk("R10 store data", wd, 16'h0050);
      repeat (2) @(negedge clk);
      chk("R10 memory written", mem[8'h50], 16'h0050);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule